// File: doc/BRIEF.md
# Two-Key Register Write Guard

This block sits between a register bus master and a peripheral's configuration register file and decides, write by write, whether a write may reach the registers. One address on the bus is a key register that the register file never sees. A two-step key sequence written there opens the guard, and any other value written there closes it again. While the guard is closed, writes to protected addresses are taken off the bus and discarded. Reads do not pass through this block, so they are unaffected.

One other address holds the flag-clear bits. Writes to it always pass, so interrupt flags can be cleared while the guard is closed. Every address other than the key register and the flag-clear register counts as protected.

Writes arrive on a valid/ready stream. When a write is forwarded, the downstream ready is passed back upstream, so the register file can apply back-pressure. When a write is consumed by the guard itself, ready is high and nothing is held. The consumed writes are key register writes and dropped protected writes. A transfer takes place when valid and ready are both high at a clock edge. The upstream master keeps address and data stable while it waits.

Top module: `wp_gate`

## Requirements
- R1: After reset the guard is closed: `unlocked` is 0, and a protected write is not forwarded.
- R2: The guard opens after two transfers to the key register (address 0x024). The first carries 0xCA in data bits [7:0] and the second carries 0x53. `unlocked` goes high in the cycle after the edge that accepts the second key.
- R3: While the guard is closed, a write to a protected address is accepted (`up_ready` is 1) and not forwarded (`dn_valid` is 0).
- R4: While the guard is open, a write to a protected address is forwarded with its address and data unchanged, and `up_ready` equals `dn_ready`.
- R5: A key register write is never forwarded and is always accepted at once.
- R6: While the guard is open, any transfer to the key register closes it from the next cycle. If that value is 0xCA, it also counts as the first key of a new sequence.
- R7: After a first key, a key register value other than 0x53 or 0xCA returns the guard to its idle closed state, where a following 0x53 does not open it. A repeated 0xCA keeps the sequence at the first-key point, so a following 0x53 does open it.
- R8: Writes to the flag-clear register (address 0x05C) are forwarded whether the guard is open or closed, with `up_ready` equal to `dn_ready`.
- R9: Only data bits [7:0] of a key register write are compared with the keys; bits above them have no effect.
- R10: Writes to other addresses between the two keys do not break the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream write valid |
| up_ready | output | 1 | Upstream write ready |
| up_addr | input | 12 | Write address |
| up_data | input | 32 | Write data |
| dn_valid | output | 1 | Write permitted to the register file |
| dn_ready | input | 1 | Register file ready |
| dn_addr | output | 12 | Forwarded address |
| dn_data | output | 32 | Forwarded data |
| unlocked | output | 1 | 1 while protected writes are permitted |

## Verification
Directed sequences check the following cases:
- the plain two-key unlock;
- a repeated first key;
- a wrong second key followed by the right one, which must stay closed;
- relocking with 0xFF and with 0xCA;
- first keys that carry noise in their upper data bits;
- protected writes placed between the keys.

Together these tell the restart path apart from the idle path in the sequence logic. Flag-clear and protected writes are each sent with the guard open and closed, and with downstream ready held low. This separates writes that are dropped from writes that are stalled. A long random mix of key values, addresses and downstream ready is then checked cycle by cycle against a bench model of the key sequence.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int KEY_W = 8;
  localparam logic [KEY_W-1:0] KEY_FIRST  = 8'hCA;
  localparam logic [KEY_W-1:0] KEY_SECOND = 8'h53;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_HALF   = 2'd1,
    ST_OPEN   = 2'd2
  } wp_state_e;
endpackage

// File: rtl/wp_addr_decode.sv
module wp_addr_decode #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 12'h024,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 12'h05C
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_key,
  output logic              is_clr,
  output logic              is_prot
);
  always_comb begin
    is_key  = (addr == KEY_ADDR);
    is_clr  = (addr == CLR_ADDR);
    is_prot = !is_key && !is_clr;
  end
endmodule

// File: rtl/wp_key_fsm.sv
module wp_key_fsm
  import wp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_byte,
  output logic             unlocked
);
  wp_state_e state_q, state_d;
  logic is_first, is_second;

  always_comb begin
    is_first  = (key_byte == KEY_FIRST);
    is_second = (key_byte == KEY_SECOND);
    state_d   = state_q;
    if (key_wr) begin
      unique case (state_q)
        ST_LOCKED: state_d = is_first ? ST_HALF : ST_LOCKED;
        ST_HALF: begin
          if (is_second)     state_d = ST_OPEN;
          else if (is_first) state_d = ST_HALF;
          else               state_d = ST_LOCKED;
        end
        ST_OPEN:   state_d = is_first ? ST_HALF : ST_LOCKED;
        default:   state_d = ST_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_LOCKED;
    else        state_q <= state_d;
  end

  assign unlocked = (state_q == ST_OPEN);
endmodule

// File: rtl/wp_write_filter.sv
module wp_write_filter (
  input  logic up_valid,
  input  logic is_key,
  input  logic is_clr,
  input  logic is_prot,
  input  logic unlocked,
  input  logic dn_ready,
  output logic dn_valid,
  output logic up_ready,
  output logic key_wr
);
  logic pass;

  always_comb begin
    pass     = is_clr || (is_prot && unlocked);
    dn_valid = up_valid && pass;
    up_ready = pass ? dn_ready : 1'b1;
    key_wr   = up_valid && is_key;
  end
endmodule

// File: rtl/wp_gate.sv
module wp_gate
  import wp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 12'h024,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 12'h05C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_data,
  output logic              unlocked
);
  logic is_key, is_clr, is_prot, key_wr;

  wp_addr_decode #(
    .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .CLR_ADDR(CLR_ADDR)
  ) u_dec (
    .addr(up_addr), .is_key(is_key), .is_clr(is_clr), .is_prot(is_prot)
  );

  wp_key_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr),
    .key_byte(up_data[KEY_W-1:0]), .unlocked(unlocked)
  );

  wp_write_filter u_flt (
    .up_valid(up_valid), .is_key(is_key), .is_clr(is_clr), .is_prot(is_prot),
    .unlocked(unlocked), .dn_ready(dn_ready), .dn_valid(dn_valid),
    .up_ready(up_ready), .key_wr(key_wr)
  );

  assign dn_addr = up_addr;
  assign dn_data = up_data;
endmodule

// File: rtl/wp_gate_chk.sv
module wp_gate_chk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 12'h024,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 12'h05C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_valid,
  input logic              up_ready,
  input logic [ADDR_W-1:0] up_addr,
  input logic [7:0]        key_byte,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic              unlocked
);
  logic a_key, a_clr;
  assign a_key = (up_addr == KEY_ADDR);
  assign a_clr = (up_addr == CLR_ADDR);

  AST_LOCKED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && up_valid && !a_key && !a_clr) |-> (!dn_valid && up_ready)); // R3

  AST_OPEN_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> (up_ready == dn_ready)); // R4

  AST_KEY_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && a_key) |-> (!dn_valid && up_ready)); // R5

  AST_CLEAR_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && a_clr) |-> dn_valid); // R8

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(up_valid && a_key && key_byte == 8'h53)); // R2

  AST_KEY_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && up_valid && a_key) |=> !unlocked); // R6
endmodule

bind wp_gate wp_gate_chk #(
  .ADDR_W(ADDR_W), .KEY_ADDR(KEY_ADDR), .CLR_ADDR(CLR_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
  .up_addr(up_addr), .key_byte(up_data[7:0]), .dn_valid(dn_valid),
  .dn_ready(dn_ready), .unlocked(unlocked)
);

// File: tb/sim_wp_gate.sv
module sim_wp_gate;
  localparam int CLK_P = 10;
  localparam logic [11:0] KADR = 12'h024;
  localparam logic [11:0] CADR = 12'h05C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic up_valid = 1'b0, dn_ready = 1'b0;
  logic [11:0] up_addr = '0;
  logic [31:0] up_data = '0;
  logic up_ready, dn_valid, unlocked;
  logic [11:0] dn_addr;
  logic [31:0] dn_data;

  int checks = 0, errors = 0;
  int mst = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  wp_gate u0 (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
    .up_addr(up_addr), .up_data(up_data), .dn_valid(dn_valid),
    .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_data(dn_data),
    .unlocked(unlocked)
  );

  function automatic int next_st(int s, logic [7:0] b);
    if (b == 8'hCA) return 1;
    if (s == 1 && b == 8'h53) return 2;
    return 0;
  endfunction

  function automatic bit fwd(logic [11:0] a, int s);
    return (a == CADR) || (a != KADR && s == 2);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic [11:0] a, logic [31:0] d, bit v, bit r, string tag);
    bit ef, er;
    @(negedge clk);
    up_addr = a; up_data = d; up_valid = v; dn_ready = r;
    #(CLK_P/4);
    ef = v && fwd(a, mst);
    er = fwd(a, mst) ? r : 1'b1;
    chk(unlocked == (mst == 2), {tag, " lock state"}, unlocked, mst == 2);
    chk(dn_valid == ef, {tag, " dn_valid"}, dn_valid, ef);
    chk(up_ready == er, {tag, " up_ready"}, up_ready, er);
    if (ef) begin
      chk(dn_addr == a, "R4 addr", dn_addr, a);
      chk(dn_data == d, "R4 data", dn_data, d);
    end
    @(posedge clk);
    if (v && a == KADR) mst = next_st(mst, d[7:0]);
  endtask

  task automatic idle();
    step(12'h000, 32'h0, 1'b0, 1'b1, "idle");
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: closed after reset, protected write not forwarded
    step(12'h000, 32'h1111, 1'b1, 1'b1, "R1");
    // R2: two-key unlock, then R4 forwarding
    step(KADR, 32'hCA, 1'b1, 1'b1, "R2");
    step(KADR, 32'h53, 1'b1, 1'b1, "R2");
    step(12'h018, 32'hDEAD_BEEF, 1'b1, 1'b1, "R4");
    // R4: back-pressure passes through while open
    step(12'h018, 32'h1234_5678, 1'b1, 1'b0, "R4");
    // R6: 0xFF relocks
    step(KADR, 32'hFF, 1'b1, 1'b1, "R6");
    step(12'h018, 32'h5, 1'b1, 1'b1, "R3");
    // R6: 0xCA while open relocks and starts a new sequence
    step(KADR, 32'hCA, 1'b1, 1'b1, "R2");
    step(KADR, 32'h53, 1'b1, 1'b1, "R2");
    step(KADR, 32'hCA, 1'b1, 1'b1, "R6");
    step(KADR, 32'h53, 1'b1, 1'b1, "R6");
    step(KADR, 32'h00, 1'b1, 1'b1, "R6");
    // R7: wrong second key then 0x53 stays closed
    step(KADR, 32'hCA, 1'b1, 1'b1, "R7");
    step(KADR, 32'h00, 1'b1, 1'b1, "R7");
    step(KADR, 32'h53, 1'b1, 1'b1, "R7");
    step(12'h000, 32'h7, 1'b1, 1'b1, "R7");
    // R7: repeated first key still unlocks
    step(KADR, 32'hCA, 1'b1, 1'b1, "R7");
    step(KADR, 32'hCA, 1'b1, 1'b1, "R7");
    step(KADR, 32'h53, 1'b1, 1'b1, "R7");
    step(KADR, 32'hFF, 1'b1, 1'b1, "R6");
    // R9: upper bits of key data ignored
    step(KADR, 32'hABCD_12CA, 1'b1, 1'b1, "R9");
    step(KADR, 32'hFFFF_FF53, 1'b1, 1'b1, "R9");
    step(KADR, 32'h0000_01FF, 1'b1, 1'b1, "R9");
    // R10: protected and clear writes between keys
    step(KADR, 32'hCA, 1'b1, 1'b1, "R10");
    step(12'h004, 32'h9, 1'b1, 1'b1, "R10");
    step(CADR, 32'h1, 1'b1, 1'b1, "R10");
    step(KADR, 32'h53, 1'b1, 1'b1, "R10");
    // R8: clear register passes when open and closed, with stall
    step(CADR, 32'h3, 1'b1, 1'b0, "R8");
    step(KADR, 32'h0, 1'b1, 1'b0, "R5");
    step(CADR, 32'h3, 1'b1, 1'b1, "R8");
    step(CADR, 32'h3, 1'b1, 1'b0, "R8");
    // R5: key write never forwarded, even with dn_ready low
    step(KADR, 32'h11, 1'b1, 1'b0, "R5");
    idle();
    // random mix against the model
    for (int i = 0; i < 3000; i++) begin
      int unsigned ra, rd;
      logic [11:0] a;
      logic [31:0] d;
      ra = $urandom; rd = $urandom;
      case (ra % 6)
        0, 1: a = KADR;
        2:    a = CADR;
        3:    a = 12'h000;
        4:    a = 12'h018;
        default: a = 12'h3F0;
      endcase
      case (rd % 5)
        0, 1: d = {$urandom} & 32'hFFFF_FF00 | 32'hCA;
        2, 3: d = {$urandom} & 32'hFFFF_FF00 | 32'h53;
        default: d = $urandom;
      endcase
      step(a, d, (ra >> 8) % 4 != 0, (ra >> 12) % 3 != 0,
           (a == KADR) ? "R5/R2" : (a == CADR) ? "R8" : (mst == 2) ? "R4" : "R3");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule